// File: doc/BRIEF.md
# Selectable-Semantics Single-Precision Min/Max Unit

This block returns the smaller or the larger of two IEEE-754 single-precision operands. The rules for NaN inputs and for a pair of zeros are chosen at run time by a 4-bit mode input. The five semantics are IEEE minNum/maxNum, Java, the C macro idiom, the C++ standard-library idiom, and Fortran. The upper mode bit makes the unit compare absolute values.

For each accepted operand pair, the unit classifies both operands. It then decides whether the answer is the plain numeric minimum or maximum, operand A, operand B, or a quieted copy of A or B. It also decides whether the invalid-operation flag is raised. The result and the flag are registered, so they appear one clock after the inputs are presented. The unit is meant to serve one lane of a wider floating-point datapath.

Top module: `fp_minmax_sel`

## Requirements
- R1: Mode bits [2:0] choose the semantics: 0 = IEEE, 1 = Java, 2 = C macro, 3 = C++, 4 = Fortran. The values 5, 6 and 7 behave exactly as 0. Mode bit 3 selects absolute mode, applied the way R2 and R3 describe.
- R2: For semantics 1 to 4 in absolute mode, the sign bit (bit 31) of both operands is cleared before any classification or selection. The result therefore always has bit 31 = 0.
- R3: Under IEEE semantics, a quiet NaN paired with a number yields the number. Two NaNs yield A with fraction bit 22 set. If either operand is a signalling NaN (exponent all ones, nonzero fraction, bit 22 clear), invalid is raised and the result is A with bit 22 set when A is a NaN, otherwise B with bit 22 set. In absolute mode, magnitudes are compared, the winning operand keeps its sign, and equal magnitudes fall back to the signed comparison.
- R4: For every semantics, a signalling NaN in either operand raises invalid.
- R5: Java with any NaN input returns the following, checked in this order: A with bit 22 set if A is signalling, B with bit 22 set if B is signalling, A if A is a NaN, otherwise B.
- R6: Fortran with any NaN input returns A when B is a NaN, and B otherwise.
- R7: With any NaN input, C macro raises invalid and returns B, and C++ raises invalid and returns A.
- R8: When both operands are zeros under Java or Fortran, min returns A if A is negative and B otherwise. Max returns B if A is negative and A otherwise.
- R9: When both operands are zeros, C macro returns B and C++ returns A, for both min and max.
- R10: In all other cases the result is the numeric minimum (sel_max = 0) or maximum (sel_max = 1), with -0 ordered below +0. Invalid stays low whenever neither operand is a NaN.
- R11: result and invalid update on the clock edge after a cycle with in_valid high, and out_valid is high in exactly that following cycle. While in_valid is low, result and invalid hold their values. Reset sets out_valid, result and invalid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is presented this cycle |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| sel_max | input | 1 | 0 = minimum, 1 = maximum |
| mode | input | 4 | Bits [2:0] select the semantics; bit 3 selects absolute mode |
| out_valid | output | 1 | result and invalid belong to the pair presented last cycle |
| result | output | 32 | Selected value |
| invalid | output | 1 | Invalid-operation flag for that pair |

## Verification
Random operand pairs are drawn mostly from special classes: signed zeros, quiet and signalling NaNs with random payloads, infinities, and equal magnitudes of opposite sign. A plain numeric path therefore cannot hide a wrong NaN or zero rule. Directed pairs separate the five semantics from one another on the same inputs; Java and Fortran, for example, disagree on (quiet NaN, 1.0). A reserved mode code is shown to act as IEEE. Absolute mode is checked twice: for semantics 1 to 4, where the sign is cleared, and for IEEE, where the magnitude comparison keeps the sign. This tells apart the two meanings of mode bit 3.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    typedef enum logic [2:0] {
        SEM_IEEE = 3'd0,
        SEM_JAVA = 3'd1,
        SEM_CMAC = 3'd2,
        SEM_CPP  = 3'd3,
        SEM_FORT = 3'd4
    } sem_e;

    typedef enum logic [2:0] {
        PICK_NUM = 3'd0,
        PICK_A   = 3'd1,
        PICK_B   = 3'd2,
        PICK_QA  = 3'd3,
        PICK_QB  = 3'd4
    } pick_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
        logic neg;
    } fpcls_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic [FP_W-1:0] x,
    output fpcls_t          cls
);
    localparam int FRAC_W = FP_W - 1 - EXP_W;
    localparam int QBIT   = FRAC_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f    = x[FP_W-2 -: EXP_W];
        frac_f   = x[FRAC_W-1:0];
        cls.nan  = (&exp_f) && (|frac_f);
        cls.snan = (&exp_f) && (|frac_f) && !frac_f[QBIT];
        cls.zero = (exp_f == '0) && (frac_f == '0);
        cls.neg  = x[FP_W-1];
    end
endmodule

// File: rtl/fpmm_numeric.sv
module fpmm_numeric #(
    parameter int FP_W = 32
) (
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic            use_mag,
    input  logic            want_max,
    output logic            take_b
);
    // Map a non-NaN value to an unsigned key that orders like the number.
    function automatic logic [FP_W-1:0] order_key(input logic [FP_W-1:0] v);
        return v[FP_W-1] ? ~v : (v | {1'b1, {(FP_W-1){1'b0}}});
    endfunction

    logic [FP_W-2:0] mag_a, mag_b;
    logic            a_lt_b, b_lt_a, mag_tie;

    always_comb begin
        mag_a   = a[FP_W-2:0];
        mag_b   = b[FP_W-2:0];
        mag_tie = (mag_a == mag_b);
        if (use_mag && !mag_tie) begin
            a_lt_b = mag_a < mag_b;
            b_lt_a = mag_b < mag_a;
        end else begin
            a_lt_b = order_key(a) < order_key(b);
            b_lt_a = order_key(b) < order_key(a);
        end
        take_b = want_max ? a_lt_b : b_lt_a;
    end

    always_comb begin
        assert (!(a_lt_b && b_lt_a)) else $error("assert_order_consistent_R10");
    end
endmodule

// File: rtl/fpmm_policy.sv
module fpmm_policy
    import fpmm_pkg::*;
(
    input  fpcls_t ca,
    input  fpcls_t cb,
    input  sem_e   sem,
    input  logic   want_max,
    output pick_e  pick,
    output logic   inv
);
    logic any_nan, any_snan, two_zero;

    always_comb begin
        any_nan  = ca.nan || cb.nan;
        any_snan = ca.snan || cb.snan;
        two_zero = ca.zero && cb.zero;
        inv      = any_snan;
        pick     = PICK_NUM;
        if (sem == SEM_IEEE) begin
            if (any_snan)             pick = ca.nan ? PICK_QA : PICK_QB;
            else if (ca.nan && cb.nan) pick = PICK_QA;
            else if (ca.nan)          pick = PICK_B;
            else if (cb.nan)          pick = PICK_A;
        end else if (any_nan) begin
            unique case (sem)
                SEM_JAVA: begin
                    if (ca.snan)      pick = PICK_QA;
                    else if (cb.snan) pick = PICK_QB;
                    else              pick = ca.nan ? PICK_A : PICK_B;
                end
                SEM_FORT: pick = cb.nan ? PICK_A : PICK_B;
                SEM_CMAC: begin pick = PICK_B; inv = 1'b1; end
                default:  begin pick = PICK_A; inv = 1'b1; end
            endcase
        end else if (two_zero) begin
            unique case (sem)
                SEM_JAVA, SEM_FORT: begin
                    if (want_max) pick = ca.neg ? PICK_B : PICK_A;
                    else          pick = ca.neg ? PICK_A : PICK_B;
                end
                SEM_CMAC: pick = PICK_B;
                default:  pick = PICK_A;
            endcase
        end
    end

    always_comb begin
        if (any_snan) assert (inv) else $error("assert_snan_flag_R4");
    end
endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
    import fpmm_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  logic            sel_max,
    input  logic [3:0]      mode,
    output logic            out_valid,
    output logic [FP_W-1:0] result,
    output logic            invalid
);
    localparam int FRAC_W = FP_W - 1 - EXP_W;
    localparam logic [FP_W-1:0] QMASK    = {{(FP_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FP_W-1:0] SIGN_CLR = {1'b0, {(FP_W-1){1'b1}}};

    typedef struct packed {
        logic            vld;
        logic [FP_W-1:0] res;
        logic            inv;
    } out_st_t;

    out_st_t         st_d, st_q;
    sem_e            sem;
    logic            abs_on, use_mag, take_b, pol_inv;
    logic [FP_W-1:0] eff [2];
    fpcls_t          cls [2];
    pick_e           pick;

    always_comb begin
        unique case (mode[2:0])
            3'd1:    sem = SEM_JAVA;
            3'd2:    sem = SEM_CMAC;
            3'd3:    sem = SEM_CPP;
            3'd4:    sem = SEM_FORT;
            default: sem = SEM_IEEE;
        endcase
        abs_on  = mode[3];
        use_mag = abs_on && (sem == SEM_IEEE);
        eff[0]  = (abs_on && sem != SEM_IEEE) ? (op_a & SIGN_CLR) : op_a;
        eff[1]  = (abs_on && sem != SEM_IEEE) ? (op_b & SIGN_CLR) : op_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpmm_classify #(.FP_W(FP_W), .EXP_W(EXP_W)) u_cls (
            .x   (eff[g]),
            .cls (cls[g])
        );
    end

    fpmm_numeric #(.FP_W(FP_W)) u_num (
        .a        (eff[0]),
        .b        (eff[1]),
        .use_mag  (use_mag),
        .want_max (sel_max),
        .take_b   (take_b)
    );

    fpmm_policy u_pol (
        .ca       (cls[0]),
        .cb       (cls[1]),
        .sem      (sem),
        .want_max (sel_max),
        .pick     (pick),
        .inv      (pol_inv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.inv = pol_inv;
            unique case (pick)
                PICK_A:  st_d.res = eff[0];
                PICK_B:  st_d.res = eff[1];
                PICK_QA: st_d.res = eff[0] | QMASK;
                PICK_QB: st_d.res = eff[1] | QMASK;
                default: st_d.res = take_b ? eff[1] : eff[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign invalid   = st_q.inv;

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));
    assert_snan_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls[0].snan || cls[1].snan)) |=> invalid);
    assert_cmac_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sem == SEM_CMAC && (cls[0].nan || cls[1].nan))
        |=> (invalid && result == $past(eff[1])));
    assert_cpp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sem == SEM_CPP && cls[0].zero && cls[1].zero)
        |=> (result == $past(eff[0])));
    assert_abs_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[3] && sem != SEM_IEEE) |=> !result[FP_W-1]);
    assert_no_nan_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls[0].nan && !cls[1].nan) |=> !invalid);
endmodule

// File: tb/fp_minmax_sel_bench.sv
module fp_minmax_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        sel_max = 1'b0;
    logic [3:0]  mode = '0;
    logic        out_valid, invalid;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    fp_minmax_sel u_fp_minmax_sel (
        .clk, .rst_n, .in_valid, .op_a, .op_b, .sel_max, .mode,
        .out_valid, .result, .invalid
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit f_nan(input logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction
    function automatic bit f_snan(input logic [31:0] v);
        return f_nan(v) && !v[22];
    endfunction
    function automatic bit f_zero(input logic [31:0] v);
        return v[30:0] == 0;
    endfunction
    // true when x is numerically below y (no NaNs)
    function automatic bit f_less(input logic [31:0] x, input logic [31:0] y);
        if (x[31] != y[31]) return x[31];
        if (x[31]) return x[30:0] > y[30:0];
        return x[30:0] < y[30:0];
    endfunction

    function automatic logic [32:0] ref_model(input logic [31:0] a_in, input logic [31:0] b_in,
                                              input logic [3:0] md, input bit mx);
        logic [31:0] a, b, r;
        bit inv;
        int t;
        t = (md[2:0] > 3'd4) ? 0 : int'(md[2:0]);
        a = a_in; b = b_in;
        if (md[3] && t != 0) begin a[31] = 1'b0; b[31] = 1'b0; end
        inv = f_snan(a) || f_snan(b);
        if (t == 0) begin
            if (inv) r = f_nan(a) ? (a | 32'h0040_0000) : (b | 32'h0040_0000);
            else if (f_nan(a) && f_nan(b)) r = a | 32'h0040_0000;
            else if (f_nan(a)) r = b;
            else if (f_nan(b)) r = a;
            else if (md[3] && a[30:0] != b[30:0]) begin
                if (mx) r = (a[30:0] > b[30:0]) ? a : b;
                else    r = (a[30:0] < b[30:0]) ? a : b;
            end else begin
                if (mx) r = f_less(a, b) ? b : a;
                else    r = f_less(b, a) ? b : a;
            end
        end else if (f_nan(a) || f_nan(b)) begin
            case (t)
                1: r = f_snan(a) ? (a | 32'h0040_0000) : f_snan(b) ? (b | 32'h0040_0000) :
                       f_nan(a) ? a : b;
                4: r = f_nan(b) ? a : b;
                2: begin r = b; inv = 1; end
                default: begin r = a; inv = 1; end
            endcase
        end else if (f_zero(a) && f_zero(b)) begin
            if (t == 2) r = b;
            else if (t == 3) r = a;
            else if (mx) r = a[31] ? b : a;
            else r = a[31] ? a : b;
        end else begin
            if (mx) r = f_less(a, b) ? b : a;
            else    r = f_less(b, a) ? b : a;
        end
        return {inv, r};
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] md,
                         input bit mx, input logic [31:0] exp_r, input bit exp_i, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; mode = md; sel_max = mx;
        @(negedge clk);
        in_valid = 1'b0;
        n_tests++;
        if (!out_valid || result !== exp_r || invalid !== exp_i) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h mode=%0d max=%0d: got v=%0b r=%h i=%0b, exp v=1 r=%h i=%0b",
                     tag, a, b, md, mx, out_valid, result, invalid, exp_r, exp_i);
        end
    endtask

    task automatic apply_ref(input logic [31:0] a, input logic [31:0] b, input logic [3:0] md,
                             input bit mx, input string tag);
        logic [32:0] e;
        e = ref_model(a, b, md, mx);
        apply(a, b, md, mx, e[31:0], e[32], tag);
    endtask

    function automatic logic [31:0] rand_op(input logic [31:0] other);
        logic [31:0] v;
        v = $urandom;
        case ($urandom % 8)
            0: ;
            1: v = 32'h0000_0000;
            2: v = 32'h8000_0000;
            3: v = {v[31], 8'hFF, 1'b1, v[21:0]};
            4: v = {v[31], 8'hFF, 1'b0, v[21:1], 1'b1};
            5: v = {v[31], 8'hFF, 23'h0};
            6: v = {v[31], 4'b0111, v[26:0]};
            default: v = {~other[31], other[30:0]};
        endcase
        return v;
    endfunction

    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000, MONE = 32'hBF80_0000, TWO = 32'h4000_0000;
    localparam logic [31:0] QN = 32'h7FC0_0001, SN = 32'h7F80_0005, SNQ = 32'h7FC0_0005;

    initial begin
        logic [31:0] held_r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || result !== 32'h0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: v=%0b r=%h i=%0b, exp 0/0/0", out_valid, result, invalid);
        end
        rst_n = 1'b1;

        apply(SN, QN, 4'd1, 0, SNQ, 1, "R5 java snan A");
        apply(ONE, SN, 4'd1, 1, SNQ, 1, "R5 java snan B");
        apply(QN, ONE, 4'd1, 0, QN, 0, "R5 java qnan A");
        apply(ONE, QN, 4'd1, 0, QN, 0, "R5 java qnan B");
        apply(QN, ONE, 4'd4, 0, ONE, 0, "R6 fortran nan A");
        apply(ONE, QN, 4'd4, 1, ONE, 0, "R6 fortran nan B");
        apply(SN, ONE, 4'd4, 0, ONE, 1, "R4 fortran snan invalid");
        apply(ONE, QN, 4'd2, 0, QN, 1, "R7 cmacro nan");
        apply(ONE, QN, 4'd3, 1, ONE, 1, "R7 cpp nan");
        apply(PZ, NZ, 4'd1, 0, NZ, 0, "R8 java min zeros");
        apply(NZ, PZ, 4'd1, 1, PZ, 0, "R8 java max zeros");
        apply(NZ, PZ, 4'd4, 0, NZ, 0, "R8 fortran min zeros");
        apply(NZ, PZ, 4'd2, 0, PZ, 0, "R9 cmacro zeros");
        apply(NZ, PZ, 4'd3, 1, NZ, 0, "R9 cpp zeros");
        apply(TWO, MONE, 4'd1, 0, MONE, 0, "R10 java numeric min");
        apply(ONE, TWO, 4'd3, 1, TWO, 0, "R10 cpp numeric max");
        apply(NZ, PZ, 4'd0, 0, NZ, 0, "R10 ieee -0 below +0");
        apply(QN, ONE, 4'd0, 0, ONE, 0, "R3 ieee qnan");
        apply(SN, ONE, 4'd0, 0, SNQ, 1, "R3 ieee snan");
        apply(TWO, MONE, 4'd8, 0, MONE, 0, "R3 ieee magnitude min");
        apply(ONE, MONE, 4'd8, 1, ONE, 0, "R3 ieee magnitude tie");
        apply(MONE, TWO, 4'd9, 0, ONE, 0, "R2 java abs");
        apply(NZ, PZ, 4'd9, 0, PZ, 0, "R2 java abs zeros");
        apply(QN, ONE, 4'd5, 0, ONE, 0, "R1 reserved code acts as ieee");
        apply(TWO, MONE, 4'd13, 0, MONE, 0, "R1 reserved abs code");

        held_r = result;
        @(negedge clk);
        op_a = TWO; op_b = SN; mode = 4'd2;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || result !== held_r || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle hold: v=%0b r=%h i=%0b, exp 0/%h/0", out_valid, result, invalid, held_r);
        end

        for (int k = 0; k < N_RANDOM; k++) begin
            logic [31:0] ra, rb;
            ra = rand_op(32'h3F80_0000);
            rb = rand_op(ra);
            apply_ref(ra, rb, 4'($urandom % 16), bit'($urandom % 2), "R1-model random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule